// File: doc/BRIEF.md
# Hardwired Micro-Operation Control Sequencer

A compact accumulator processor whose control unit is built purely from gates and flip-flops, with no control store. A four-state step counter (t1 to t4) and a cycle register select the running machine cycle: fetch, indirect, execute, interrupt or halted. An op-code decoder turns the 3-bit op-code into one line per instruction. Combinational control logic combines that line with the step, the cycle and a few flags (indirect bit, memory buffer zero, pending interrupt) into register-transfer enables for the address register, buffer register, program counter, instruction register, accumulator and interrupt enable.

Instruction words are 16 bits: bit 15 selects indirect addressing, bits 14:12 hold the op-code and bits 11:0 hold the operand address. Memory sits outside the block on a simple port: the address register drives the address, the buffer register drives the write data, and read data is sampled combinationally in the step after the address register was loaded. Every instruction executes as a fixed, cycle-exact list of transfers, and the current cycle and step are brought out so their order can be checked from outside.

Top module: `hw_ctrl_seq`

## Requirements
- R1: While rst_ni is low, pc_o and acc_o read 0, cycle_o reads fetch and step_o reads t1, mem_we_o is low, mem_addr_o is 0 and interrupts are disabled.
- R2: Fetch takes three steps: t1 loads the address register from the program counter, t2 loads the buffer register from memory and increments the program counter, t3 copies the buffer register into the instruction register.
- R3: No step loads the buffer register from memory while also loading the instruction register from it, and mem_we_o is only high during the execute or interrupt cycle.
- R4: When bit 15 of the fetched word is 1, a three-step indirect cycle follows fetch: the operand address goes to the address register, memory is read into the buffer register, and the low 12 bits of the instruction register are replaced by the low 12 bits of the buffer register; the pointer word is not written.
- R5: Op-code 0 (add) executes in three steps and leaves acc_o equal to the old accumulator plus the operand word, modulo 2^16.
- R6: Op-code 1 (increment and skip) executes in four steps, writes the operand word plus one back to its address and, when that result is 0, increments the program counter once more so the next instruction is skipped.
- R7: Op-code 2 (branch and save) executes in three steps, writes the address of the following instruction to operand address X and continues execution at X+1.
- R8: Op-code 3 executes in one step and enables interrupts; the enable takes effect from the end of the next instruction.
- R9: At the end of an execute cycle with irq_i high and interrupts enabled, a three-step interrupt cycle writes the program counter to address SAVE_ADDR, loads the program counter with VEC_ADDR and disables interrupts; in every other case the next cycle is fetch.
- R10: Op-code 7 halts: cycle_o stays halted and the program counter no longer changes until reset.
- R11: Op-codes 4, 5 and 6 execute in one step with no transfer and no memory write, then the sequencer returns to fetch.
- R12: cycle_o encodes fetch as 0, indirect as 1, execute as 2, interrupt as 3 and halted as 4; step_o encodes t1 to t4 as 0 to 3, and every cycle starts at t1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory address, driven by the address register |
| mem_wdata_o | output | 16 | Memory write data, driven by the buffer register |
| mem_we_o | output | 1 | Memory write strobe for the current step |
| mem_rdata_i | input | 16 | Memory read data for the presented address |
| irq_i | input | 1 | Interrupt request, level sensitive |
| cycle_o | output | 3 | Current machine cycle |
| step_o | output | 2 | Current timing step |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |

## Verification
The bench sweeps add operands across sign and carry boundaries and increment-and-skip operands around 0xFFFF, where a wrong zero test would skip on the pre-increment value or never skip, leaving the accumulator off by the skipped add. Indirect variants of add and increment-and-skip catch a design that writes the pointer word or executes with the pointer itself as operand. The interrupt program holds irq_i high from reset, so a design that powers up enabled, applies the enable in the same instruction, or fails to clear it on entry would take the interrupt too early or loop back into it, showing up as a wrong saved address, final program counter or cycle trace. Undefined op-codes and branch-and-save are checked against the full cycle/step trace, so an extra or missing step anywhere is visible.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  localparam int unsigned N_STEPS = 4;
  localparam int unsigned STEP_W  = $clog2(N_STEPS);

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_INDIR = 3'd1,
    CYC_EXEC  = 3'd2,
    CYC_INTR  = 3'd3,
    CYC_HALT  = 3'd4
  } cycle_e;

  localparam int unsigned OP_ADD = 0;
  localparam int unsigned OP_ISZ = 1;
  localparam int unsigned OP_BSA = 2;
  localparam int unsigned OP_ION = 3;
  localparam int unsigned OP_HLT = 7;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_inc;
    logic ir_mbr;
    logic ir_adr_mbr;
    logic pc_inc;
    logic pc_ir;
    logic pc_vec;
    logic acc_add;
    logic mem_we;
    logic ie_set;
    logic ie_clr;
    logic done;
  } ctrl_t;

endpackage

// File: rtl/hcs_op_decoder.sv
module hcs_op_decoder #(
  parameter int unsigned OP_W = 3
) (
  input  logic [OP_W-1:0]        op_i,
  output logic [(1<<OP_W)-1:0]   line_o
);

  localparam int unsigned N_LINES = 1 << OP_W;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign line_o[i] = (op_i == OP_W'(i));
  end

endmodule

// File: rtl/hcs_step_timer.sv
module hcs_step_timer
  import hcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  cycle_e            next_i,
  output cycle_e            cycle_o,
  output logic [STEP_W-1:0] step_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_o <= CYC_FETCH;
      step_o  <= '0;
    end else if (cycle_o != CYC_HALT) begin
      if (done_i) begin
        cycle_o <= next_i;
        step_o  <= '0;
      end else begin
        step_o  <= step_o + 1'b1;
      end
    end
  end

  // R10: halted state is terminal
  p_halt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_o == CYC_HALT |=> cycle_o == CYC_HALT);

  // R6: only the increment-and-skip execute reaches t4
  p_t4_exec_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o == STEP_W'(3) |-> cycle_o == CYC_EXEC);

  // R12: a new cycle always starts at t1
  p_cycle_start_t1_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && cycle_o != CYC_HALT) |=> step_o == '0);

endmodule

// File: rtl/hcs_ctrl_logic.sv
module hcs_ctrl_logic
  import hcs_pkg::*;
#(
  parameter int unsigned OP_W = 3
) (
  input  cycle_e                 cycle_i,
  input  logic [STEP_W-1:0]      step_i,
  input  logic [(1<<OP_W)-1:0]   line_i,
  input  logic                   ind_i,
  input  logic                   zero_i,
  input  logic                   irq_pend_i,
  output ctrl_t                  ctrl_o,
  output cycle_e                 next_o
);

  localparam int unsigned N_LINES = 1 << OP_W;
  localparam logic [N_LINES-1:0] DEF_MASK =
      (N_LINES'(1) << OP_ADD) | (N_LINES'(1) << OP_ISZ) | (N_LINES'(1) << OP_BSA) |
      (N_LINES'(1) << OP_ION) | (N_LINES'(1) << OP_HLT);

  logic undef_w;
  logic end_exec;

  assign undef_w = ~|(line_i & DEF_MASK);

  always_comb begin
    ctrl_o   = '0;
    next_o   = cycle_i;
    end_exec = 1'b0;
    case (cycle_i)
      CYC_FETCH: begin
        case (step_i)
          2'd0: ctrl_o.mar_pc = 1'b1;
          2'd1: begin
            ctrl_o.mbr_mem = 1'b1;
            ctrl_o.pc_inc  = 1'b1;
          end
          2'd2: begin
            ctrl_o.ir_mbr = 1'b1;
            ctrl_o.done   = 1'b1;
            next_o        = ind_i ? CYC_INDIR : CYC_EXEC;
          end
          default: ;
        endcase
      end
      CYC_INDIR: begin
        case (step_i)
          2'd0: ctrl_o.mar_ir  = 1'b1;
          2'd1: ctrl_o.mbr_mem = 1'b1;
          2'd2: begin
            ctrl_o.ir_adr_mbr = 1'b1;
            ctrl_o.done       = 1'b1;
            next_o            = CYC_EXEC;
          end
          default: ;
        endcase
      end
      CYC_EXEC: begin
        if (undef_w) begin
          end_exec = 1'b1;
        end else if (line_i[OP_ADD]) begin
          case (step_i)
            2'd0: ctrl_o.mar_ir  = 1'b1;
            2'd1: ctrl_o.mbr_mem = 1'b1;
            2'd2: begin
              ctrl_o.acc_add = 1'b1;
              end_exec       = 1'b1;
            end
            default: ;
          endcase
        end else if (line_i[OP_ISZ]) begin
          case (step_i)
            2'd0: ctrl_o.mar_ir  = 1'b1;
            2'd1: ctrl_o.mbr_mem = 1'b1;
            2'd2: ctrl_o.mbr_inc = 1'b1;
            default: begin
              ctrl_o.mem_we = 1'b1;
              ctrl_o.pc_inc = zero_i;  // skip on incremented value
              end_exec      = 1'b1;
            end
          endcase
        end else if (line_i[OP_BSA]) begin
          case (step_i)
            2'd0: begin
              ctrl_o.mar_ir = 1'b1;
              ctrl_o.mbr_pc = 1'b1;
            end
            2'd1: begin
              ctrl_o.pc_ir  = 1'b1;
              ctrl_o.mem_we = 1'b1;
            end
            2'd2: begin
              ctrl_o.pc_inc = 1'b1;
              end_exec      = 1'b1;
            end
            default: ;
          endcase
        end else if (line_i[OP_ION]) begin
          ctrl_o.ie_set = 1'b1;
          end_exec      = 1'b1;
        end else begin
          end_exec = 1'b1;  // halt
        end
      end
      CYC_INTR: begin
        case (step_i)
          2'd0: ctrl_o.mbr_pc = 1'b1;
          2'd1: begin
            ctrl_o.mar_save = 1'b1;
            ctrl_o.pc_vec   = 1'b1;
          end
          2'd2: begin
            ctrl_o.mem_we = 1'b1;
            ctrl_o.done   = 1'b1;
            next_o        = CYC_FETCH;
          end
          default: ;
        endcase
      end
      default: ;
    endcase

    if (end_exec) begin
      ctrl_o.done = 1'b1;
      if (line_i[OP_HLT]) begin
        next_o = CYC_HALT;
      end else if (irq_pend_i) begin
        next_o        = CYC_INTR;
        ctrl_o.ie_clr = 1'b1;
      end else begin
        next_o = CYC_FETCH;
      end
    end
  end

endmodule

// File: rtl/hcs_datapath.sv
module hcs_datapath
  import hcs_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SAVE_ADDR = 12'hFF0,
  parameter int unsigned VEC_ADDR  = 12'hFF1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              ie_o
);

  localparam int unsigned PAD_W = DATA_W - ADDR_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mar_o <= '0;
    else if (ctrl_i.mar_pc)   mar_o <= pc_o;
    else if (ctrl_i.mar_ir)   mar_o <= ir_o[ADDR_W-1:0];
    else if (ctrl_i.mar_save) mar_o <= ADDR_W'(SAVE_ADDR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             mbr_o <= '0;
    else if (ctrl_i.mbr_mem) mbr_o <= rdata_i;
    else if (ctrl_i.mbr_pc)  mbr_o <= {{PAD_W{1'b0}}, pc_o};
    else if (ctrl_i.mbr_inc) mbr_o <= mbr_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ir_o <= '0;
    else if (ctrl_i.ir_mbr)     ir_o <= mbr_o;
    else if (ctrl_i.ir_adr_mbr) ir_o[ADDR_W-1:0] <= mbr_o[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pc_o <= '0;
    else if (ctrl_i.pc_ir)  pc_o <= ir_o[ADDR_W-1:0];
    else if (ctrl_i.pc_vec) pc_o <= ADDR_W'(VEC_ADDR);
    else if (ctrl_i.pc_inc) pc_o <= pc_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             acc_o <= '0;
    else if (ctrl_i.acc_add) acc_o <= acc_o + mbr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ie_o <= 1'b0;
    else if (ctrl_i.ie_clr) ie_o <= 1'b0;
    else if (ctrl_i.ie_set) ie_o <= 1'b1;
  end

  // R3: buffer load from memory never shares a step with an IR load from it
  p_no_mbr_ir_clash_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.mbr_mem |-> !(ctrl_i.ir_mbr || ctrl_i.ir_adr_mbr));

endmodule

// File: rtl/hw_ctrl_seq.sv
module hw_ctrl_seq
  import hcs_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned OP_W      = 3,
  parameter int unsigned SAVE_ADDR = 12'hFF0,
  parameter int unsigned VEC_ADDR  = 12'hFF1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              irq_i,
  output logic [2:0]        cycle_o,
  output logic [STEP_W-1:0] step_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);

  localparam int unsigned N_LINES = 1 << OP_W;
  localparam int unsigned OP_MSB  = DATA_W - 2;
  localparam int unsigned IND_BIT = DATA_W - 1;

  ctrl_t               ctrl;
  cycle_e              cycle_q;
  cycle_e              cycle_d;
  logic [STEP_W-1:0]   step_q;
  logic [N_LINES-1:0]  op_line;
  logic [ADDR_W-1:0]   mar;
  logic [DATA_W-1:0]   mbr;
  logic [ADDR_W-1:0]   pc;
  logic [DATA_W-1:0]   ir;
  logic [DATA_W-1:0]   acc;
  logic                ie;

  hcs_step_timer u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (ctrl.done),
    .next_i  (cycle_d),
    .cycle_o (cycle_q),
    .step_o  (step_q)
  );

  hcs_op_decoder #(.OP_W(OP_W)) u_dec (
    .op_i   (ir[OP_MSB -: OP_W]),
    .line_o (op_line)
  );

  hcs_ctrl_logic #(.OP_W(OP_W)) u_ctrl (
    .cycle_i    (cycle_q),
    .step_i     (step_q),
    .line_i     (op_line),
    .ind_i      (mbr[IND_BIT]),
    .zero_i     (mbr == '0),
    .irq_pend_i (irq_i & ie),
    .ctrl_o     (ctrl),
    .next_o     (cycle_d)
  );

  hcs_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
  ) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_i  (ctrl),
    .rdata_i (mem_rdata_i),
    .mar_o   (mar),
    .mbr_o   (mbr),
    .pc_o    (pc),
    .ir_o    (ir),
    .acc_o   (acc),
    .ie_o    (ie)
  );

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mbr;
  assign mem_we_o    = ctrl.mem_we;
  assign cycle_o     = cycle_q;
  assign step_o      = step_q;
  assign pc_o        = pc;
  assign acc_o       = acc;

  p_fetch_pc_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_q == CYC_FETCH && step_q == STEP_W'(1)) |=> pc == ADDR_W'($past(pc) + 1'b1));

  p_fetch_ir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_q == CYC_FETCH && step_q == STEP_W'(2)) |=> ir == $past(mbr));

  p_we_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (cycle_q == CYC_EXEC || cycle_q == CYC_INTR));

  p_indir_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_q == CYC_INDIR && step_q == STEP_W'(2)) |=> ir[ADDR_W-1:0] == $past(mbr[ADDR_W-1:0]));

  p_intr_ie_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_q == CYC_INTR |-> !ie);

  p_halt_pc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_q == CYC_HALT |=> $stable(pc));

endmodule

// File: tb/tb_hw_ctrl_seq.sv
`timescale 1ns/1ps
module tb_hw_ctrl_seq;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_we_o;
  logic [15:0] mem_rdata_i;
  logic        irq_i = 1'b0;
  logic [2:0]  cycle_o;
  logic [1:0]  step_o;
  logic [11:0] pc_o;
  logic [15:0] acc_o;

  logic [15:0] mem [4096];
  logic [4:0]  exp_tr [256];
  logic [4:0]  act_tr [256];
  int          exp_n, act_n, we_bad;
  int          n_chk = 0, n_err = 0;

  always #10 clk_i = ~clk_i;

  hw_ctrl_seq dut (
    .clk_i, .rst_ni, .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_rdata_i,
    .irq_i, .cycle_o, .step_o, .pc_o, .acc_o
  );

  assign mem_rdata_i = mem[mem_addr_o];
  always @(posedge clk_i) if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;

  localparam int CF = 0, CI = 1, CE = 2, CN = 3, CH = 4;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic seg(input int cyc, input int n);
    for (int s = 0; s < n; s++) begin
      exp_tr[exp_n] = {cyc[2:0], s[1:0]};
      exp_n++;
    end
  endtask

  task automatic begin_test();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    exp_n = 0;
    @(negedge clk_i);
  endtask

  task automatic run_prog();
    act_n  = 0;
    we_bad = 0;
    rst_ni = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      if (act_n < 256) act_tr[act_n] = {cycle_o, step_o};
      act_n++;
      if (mem_we_o && cycle_o != 3'd2 && cycle_o != 3'd3) we_bad++;
      if (cycle_o == 3'd4) break;
      @(negedge clk_i);
    end
    chk("R10 halt reached", 32'(cycle_o), 32'd4);
    chk("R3 write only in execute/interrupt", 32'(we_bad), 32'd0);
  endtask

  task automatic chk_trace(input string tag);
    int k;
    k = -1;
    chk({tag, " trace length"}, 32'(act_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < act_n; i++)
      if (k < 0 && act_tr[i] !== exp_tr[i]) k = i;
    if (k >= 0) chk({tag, " trace step"}, 32'(act_tr[k]), 32'(exp_tr[k]));
    else chk({tag, " trace step"}, 32'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    logic [15:0] isz_v [6];
    logic [11:0] bsa_x [2];
    logic [11:0] pc_hold;
    vals  = '{16'h0000, 16'h0001, 16'h7FFF, 16'hFFFF, 16'h8000, 16'h1234};
    isz_v = '{16'hFFFF, 16'hFFFE, 16'h0000, 16'h0001, 16'h7FFF, 16'h8000};
    bsa_x = '{12'h300, 12'h7F0};

    // R1: reset state
    begin_test();
    chk("R1 pc", 32'(pc_o), 32'd0);
    chk("R1 acc", 32'(acc_o), 32'd0);
    chk("R1 cycle", 32'(cycle_o), 32'd0);
    chk("R1 step", 32'(step_o), 32'd0);
    chk("R1 we", 32'(mem_we_o), 32'd0);
    chk("R1 addr", 32'(mem_addr_o), 32'd0);

    // R5 / R2 / R12: add sweep
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        begin_test();
        mem[0] = 16'h0100; mem[1] = 16'h0101; mem[2] = 16'h7000;
        mem[12'h100] = vals[i]; mem[12'h101] = vals[j];
        seg(CF, 3); seg(CE, 3); seg(CF, 3); seg(CE, 3); seg(CF, 3); seg(CE, 1); seg(CH, 1);
        run_prog();
        chk("R5 add sum", 32'(acc_o), 32'(16'(vals[i] + vals[j])));
        chk("R2 pc after fetches", 32'(pc_o), 32'd3);
        chk_trace("R12 R2 add");
      end
    end

    // R6: increment and skip sweep
    for (int i = 0; i < 6; i++) begin
      logic [15:0] inc;
      logic        skip;
      inc  = isz_v[i] + 16'h1;
      skip = (inc == 16'h0);
      begin_test();
      mem[0] = 16'h1200; mem[1] = 16'h0201; mem[2] = 16'h7000;
      mem[12'h200] = isz_v[i]; mem[12'h201] = 16'h0001;
      seg(CF, 3); seg(CE, 4);
      if (!skip) begin seg(CF, 3); seg(CE, 3); end
      seg(CF, 3); seg(CE, 1); seg(CH, 1);
      run_prog();
      chk("R6 written back", 32'(mem[12'h200]), 32'(inc));
      chk("R6 skip effect", 32'(acc_o), skip ? 32'd0 : 32'd1);
      chk("R6 pc", 32'(pc_o), 32'd3);
      chk_trace("R6 isz");
    end

    // R7: branch and save
    for (int i = 0; i < 2; i++) begin
      begin_test();
      mem[0] = {4'h2, bsa_x[i]};
      mem[bsa_x[i]] = 16'hDEAD;
      mem[bsa_x[i] + 12'd1] = 16'h0010;
      mem[bsa_x[i] + 12'd2] = 16'h7000;
      mem[12'h010] = 16'h0005;
      seg(CF, 3); seg(CE, 3); seg(CF, 3); seg(CE, 3); seg(CF, 3); seg(CE, 1); seg(CH, 1);
      run_prog();
      chk("R7 return address saved", 32'(mem[bsa_x[i]]), 32'd1);
      chk("R7 resumed at X+1", 32'(acc_o), 32'd5);
      chk("R7 pc", 32'(pc_o), 32'(bsa_x[i] + 12'd3));
      chk_trace("R7 bsa");
    end

    // R4: indirect add and indirect increment-and-skip
    begin_test();
    mem[0] = 16'h8050; mem[1] = 16'h9051; mem[2] = 16'h0120; mem[3] = 16'h7000;
    mem[12'h050] = 16'h0120; mem[12'h051] = 16'h0121;
    mem[12'h120] = 16'h0007; mem[12'h121] = 16'hFFFF;
    seg(CF, 3); seg(CI, 3); seg(CE, 3); seg(CF, 3); seg(CI, 3); seg(CE, 4);
    seg(CF, 3); seg(CE, 1); seg(CH, 1);
    run_prog();
    chk("R4 indirect add operand", 32'(acc_o), 32'd7);
    chk("R4 indirect isz target", 32'(mem[12'h121]), 32'd0);
    chk("R4 pointer untouched", 32'(mem[12'h050]), 32'h120);
    chk("R4 skip pc", 32'(pc_o), 32'd4);
    chk_trace("R4 indirect");

    // R11: undefined op-codes, R10: halt holds
    begin_test();
    mem[0] = 16'h4ABC; mem[1] = 16'h5ABC; mem[2] = 16'h6ABC; mem[3] = 16'h7000;
    mem[12'hABC] = 16'h00F0;
    seg(CF, 3); seg(CE, 1); seg(CF, 3); seg(CE, 1); seg(CF, 3); seg(CE, 1);
    seg(CF, 3); seg(CE, 1); seg(CH, 1);
    run_prog();
    chk("R11 acc untouched", 32'(acc_o), 32'd0);
    chk("R11 memory untouched", 32'(mem[12'hABC]), 32'h00F0);
    chk("R11 pc", 32'(pc_o), 32'd4);
    chk_trace("R11 undefined");
    pc_hold = pc_o;
    repeat (5) @(negedge clk_i);
    chk("R10 still halted", 32'(cycle_o), 32'd4);
    chk("R10 pc frozen", 32'(pc_o), 32'(pc_hold));

    // R8 / R9 / R1: interrupt with request held from reset
    begin_test();
    irq_i = 1'b1;
    mem[0] = 16'h0100; mem[1] = 16'h3000; mem[2] = 16'h0101; mem[3] = 16'h7000;
    mem[12'h100] = 16'h0003; mem[12'h101] = 16'h0004; mem[12'h102] = 16'h0010;
    mem[12'hFF1] = 16'h0102; mem[12'hFF2] = 16'h7000;
    seg(CF, 3); seg(CE, 3); seg(CF, 3); seg(CE, 1); seg(CF, 3); seg(CE, 3);
    seg(CN, 3); seg(CF, 3); seg(CE, 3); seg(CF, 3); seg(CE, 1); seg(CH, 1);
    run_prog();
    chk("R9 saved pc", 32'(mem[12'hFF0]), 32'd3);
    chk("R9 enable cleared, no re-entry", 32'(pc_o), 32'hFF3);
    chk("R8 enable timing", 32'(acc_o), 32'h17);
    chk_trace("R9 R8 R1 interrupt");
    irq_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule